// File: doc/BRIEF.md
# Word/Byte Flash Host Bus Front End

This block sits between the host pins of a flash memory model and its storage array. It takes active-low chip select, read strobe and write strobe inputs and a width-select input. It also takes a word address and a 16-bit bidirectional data bus, which is split into an input vector, an output vector and a per-pin drive-enable vector. From these it forms the byte-granular address and passes the word address to the array. It latches the returned array word, picks the lane that belongs on the pins, and drives only the pins that the current width and strobes allow.

In narrow (byte) mode the top data pin stops carrying data and becomes the lowest address bit, below the word address. That bit chooses which half of the array word appears on the low eight pins. An address-stability timer runs independently of the strobes. Once the full address key (width mode, word address and, in byte mode, the low address bit) has held for a set number of clock edges, the block enters a low-power sleep state. In sleep it stops sampling the array and holds its output latch. The first change of address key wakes it and loads fresh data on the same edge.

Top module: `flashif_bus_front`

## Requirements
- R1: With `wide_cfg`=1 (word mode) and a read enabled, all 16 bits of `dq_oe` are 1.
- R2: With `wide_cfg`=0 (byte mode), `dq_oe[15:8]` is always 0 and `dq_oe[7:0]` follows the read enable.
- R3: `arr_addr` equals `addr_i`. `byte_addr` is {`addr_i`, lsb}, where lsb is `dq_i[15]` in byte mode and 0 in word mode.
- R4: The latched value is the full array word in word mode. In byte mode it is {8'h00, lane}, where lane is word bits 7:0 when lsb=0 and word bits 15:8 when lsb=1.
- R5: The read enable is true only when `ce_n`=0, `oe_n`=0 and `we_n`=1. Otherwise every bit of `dq_oe` is 0, and in particular `oe_n`=1 forces all 16 bits to 0.
- R6: While awake, `dq_o` shows the value formed from `arr_rdata` and the inputs sampled at the most recent rising clock edge (one register stage).
- R7: `asleep` becomes 1 after the edge at which the address key has been unchanged for SLEEP_CYC = ACC_CYC + SLEEP_EXTRA consecutive edges since it last changed. The strobes `ce_n`, `oe_n` and `we_n` do not affect this. In word mode `dq_i[15]` is not part of the key.
- R8: While asleep and the key is unchanged, `dq_o` holds its value even if `arr_rdata` changes.
- R9: A change of address key (word address, mode, or byte-mode lsb) clears `asleep` after that edge and loads new data on the same edge.
- R10: While `rst_n`=0, `asleep` is 0 and `dq_o` is 0. The stored key resets to all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Read strobe (output enable), active low |
| we_n | input | 1 | Write strobe, active low |
| wide_cfg | input | 1 | 1 = word mode, 0 = byte mode |
| addr_i | input | ADDR_W | Word address |
| dq_i | input | DATA_W | Data pins, input side (top bit is the address lsb in byte mode) |
| dq_o | output | DATA_W | Data pins, output side |
| dq_oe | output | DATA_W | Per-pin drive enable |
| arr_addr | output | ADDR_W | Word address to the array |
| arr_rdata | input | DATA_W | Array read word |
| byte_addr | output | ADDR_W+1 | Byte-granular address |
| asleep | output | 1 | Automatic sleep state |

## Verification
Two functions can act on the same edge: the sleep timer deciding to hold the latch, and an address change that must both wake the block and reload it. The bench keeps the address steady until `asleep` is set, and changes the array contents while asleep. It then moves the address, and in byte mode toggles only the top data pin, on an edge where the hold would otherwise apply. A behavioural model, updated on every rising edge, gives the expected latch value and sleep flag. These are compared with the outputs at every falling edge, so a reload that is one edge late, or a wake that does not happen, shows up as a mismatch on the exact cycle.

// File: rtl/flashif_pkg.sv
package flashif_pkg;
   typedef enum logic {
      MODE_BYTE = 1'b0,
      MODE_WORD = 1'b1
   } bus_mode_e;

   function automatic bus_mode_e mode_of(input logic wide);
      return wide ? MODE_WORD : MODE_BYTE;
   endfunction
endpackage

// File: rtl/flashif_addr_former.sv
module flashif_addr_former
   import flashif_pkg::*;
#(
   parameter int ADDR_W = 20
) (
   input  logic              wide_cfg,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              lsb_pin,
   output logic [ADDR_W:0]   byte_addr,
   output logic [ADDR_W+1:0] key
);
   logic lsb;

   always_comb begin
      lsb = (mode_of(wide_cfg) == MODE_BYTE) ? lsb_pin : 1'b0;
      byte_addr = {addr_i, lsb};
      key = {wide_cfg, byte_addr};
   end
endmodule

// File: rtl/flashif_sleep_timer.sv
module flashif_sleep_timer #(
   parameter int KEY_W = 22,
   parameter int LIM   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [KEY_W-1:0] key,
   output logic             chg,
   output logic             asleep
);
   localparam int CNT_W = $clog2(LIM + 1);
   localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIM);

   logic [KEY_W-1:0] key_q;
   logic [CNT_W-1:0] cnt;

   generate
      if (LIM < 1) begin : g_bad_lim
         $error("sleep limit must be at least one cycle");
      end
   endgenerate

   assign chg    = (key != key_q);
   assign asleep = (cnt == LIM_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         key_q <= '0;
         cnt   <= '0;
      end else begin
         key_q <= key;
         if (chg)
            cnt <= '0;
         else if (cnt != LIM_C)
            cnt <= cnt + 1'b1;
      end
   end

   // R9: any key change wakes the block after that edge
   p_wake_on_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
      chg |=> !asleep);

   // R7: sleep is entered only after an edge with an unchanged key
   p_entry_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(asleep) |-> $past(!chg));

   // R7: once asleep, an unchanged key keeps it asleep
   p_stay_asleep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && !chg) |=> asleep);
endmodule

// File: rtl/flashif_data_latch.sv
module flashif_data_latch
   import flashif_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              wide_cfg,
   input  logic              lane_sel,
   input  logic [DATA_W-1:0] word_i,
   output logic [DATA_W-1:0] data_q
);
   localparam int HALF = DATA_W / 2;

   logic [HALF-1:0]   lane;
   logic [DATA_W-1:0] nxt;

   generate
      if (DATA_W % 2 != 0) begin : g_bad_width
         $error("data width must be even");
      end
   endgenerate

   always_comb begin
      lane = lane_sel ? word_i[DATA_W-1:HALF] : word_i[HALF-1:0];
      if (mode_of(wide_cfg) == MODE_WORD)
         nxt = word_i;
      else
         nxt = {{HALF{1'b0}}, lane};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         data_q <= '0;
      else if (load)
         data_q <= nxt;
   end
endmodule

// File: rtl/flashif_pin_ctrl.sv
module flashif_pin_ctrl #(
   parameter int DATA_W = 16
) (
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              wide_cfg,
   output logic              rd_en,
   output logic [DATA_W-1:0] dq_oe
);
   localparam int HALF = DATA_W / 2;

   assign rd_en = !ce_n && !oe_n && we_n;

   generate
      for (genvar i = 0; i < DATA_W; i++) begin : g_pin
         if (i < HALF) begin : g_low
            assign dq_oe[i] = rd_en;
         end else begin : g_high
            assign dq_oe[i] = rd_en && wide_cfg;
         end
      end
   endgenerate
endmodule

// File: rtl/flashif_bus_front.sv
module flashif_bus_front #(
   parameter int ADDR_W      = 20,
   parameter int DATA_W      = 16,
   parameter int ACC_CYC     = 4,
   parameter int SLEEP_EXTRA = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              wide_cfg,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] dq_i,
   output logic [DATA_W-1:0] dq_o,
   output logic [DATA_W-1:0] dq_oe,
   output logic [ADDR_W-1:0] arr_addr,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [ADDR_W:0]   byte_addr,
   output logic              asleep
);
   localparam int SLEEP_CYC = ACC_CYC + SLEEP_EXTRA;
   localparam int KEY_W     = ADDR_W + 2;
   localparam int HALF      = DATA_W / 2;

   logic [KEY_W-1:0] key;
   logic             chg;
   logic             rd_en;
   logic             unused_dq_low;

   generate
      if (ADDR_W < 1) begin : g_bad_addr
         $error("address width must be positive");
      end
      if (ACC_CYC < 1 || SLEEP_EXTRA < 0) begin : g_bad_time
         $error("access time must be positive and sleep delay non-negative");
      end
   endgenerate

   assign unused_dq_low = ^dq_i[DATA_W-2:0];
   assign arr_addr      = addr_i;

   flashif_addr_former #(.ADDR_W(ADDR_W)) u_addr (
      .wide_cfg (wide_cfg),
      .addr_i   (addr_i),
      .lsb_pin  (dq_i[DATA_W-1]),
      .byte_addr(byte_addr),
      .key      (key)
   );

   flashif_sleep_timer #(.KEY_W(KEY_W), .LIM(SLEEP_CYC)) u_timer (
      .clk   (clk),
      .rst_n (rst_n),
      .key   (key),
      .chg   (chg),
      .asleep(asleep)
   );

   flashif_data_latch #(.DATA_W(DATA_W)) u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (!asleep || chg),
      .wide_cfg(wide_cfg),
      .lane_sel(byte_addr[0]),
      .word_i  (arr_rdata),
      .data_q  (dq_o)
   );

   flashif_pin_ctrl #(.DATA_W(DATA_W)) u_pins (
      .ce_n    (ce_n),
      .oe_n    (oe_n),
      .we_n    (we_n),
      .wide_cfg(wide_cfg),
      .rd_en   (rd_en),
      .dq_oe   (dq_oe)
   );

   // R1: word-mode read drives every pin
   p_word_all_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wide_cfg && !ce_n && !oe_n && we_n) |-> (&dq_oe));

   // R2: byte mode never drives the upper pins
   p_byte_upper_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wide_cfg |-> (dq_oe[DATA_W-1:HALF] == '0));

   // R3: lowest byte address bit comes from the top pin only in byte mode
   p_lsb_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
      byte_addr[0] == (!wide_cfg && dq_i[DATA_W-1]));

   // R5: no pin is driven without a full read condition
   p_no_drive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (oe_n || ce_n || !we_n) |-> (dq_oe == '0));

   // R8: the output latch holds while asleep with an unchanged key
   p_hold_asleep_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (asleep && !chg) |=> $stable(dq_o));

   // R4: a byte-mode load leaves the upper output half at zero
   p_byte_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!wide_cfg && chg) |=> (dq_o[DATA_W-1:HALF] == '0));
endmodule

// File: tb/flashif_bus_front_tb.sv
module flashif_bus_front_tb;
   localparam int AW    = 20;
   localparam int DW    = 16;
   localparam int ACC   = 4;
   localparam int EXTRA = 2;
   localparam int LIM   = ACC + EXTRA;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, wide_cfg = 1'b1;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] dq_i = '0;
   logic [DW-1:0] dq_o, dq_oe, arr_rdata;
   logic [AW-1:0] arr_addr;
   logic [AW:0]   byte_addr;
   logic          asleep;
   logic [15:0]   salt = 16'h1234;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;
   bit live   = 0;
   string tag_pins = "R5";
   string tag_data = "R6";
   string tag_slp  = "R7";

   always #10 clk = ~clk;

   function automatic logic [15:0] arrf(input logic [AW-1:0] a, input logic [15:0] s);
      logic [15:0] p;
      p = 16'(a[15:0] * 16'h03b5);
      return p ^ s ^ 16'h5a5a ^ {12'h0, a[AW-1:AW-4]};
   endfunction

   assign arr_rdata = arrf(addr_i, salt);

   flashif_bus_front #(.ADDR_W(AW), .DATA_W(DW), .ACC_CYC(ACC), .SLEEP_EXTRA(EXTRA)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .wide_cfg(wide_cfg), .addr_i(addr_i), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
      .arr_addr(arr_addr), .arr_rdata(arr_rdata), .byte_addr(byte_addr), .asleep(asleep)
   );

   // behavioural reference
   logic [AW+1:0] m_key;
   int            m_cnt;
   logic [15:0]   m_data;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_key  = '0;
         m_cnt  = 0;
         m_data = '0;
      end else begin
         logic [AW+1:0] k;
         logic [15:0]   w;
         bit            was_asleep;
         k = {wide_cfg, addr_i, (!wide_cfg) & dq_i[15]};
         w = arrf(addr_i, salt);
         was_asleep = (m_cnt == LIM);
         if (k != m_key || !was_asleep)
            m_data = wide_cfg ? w : {8'h00, (dq_i[15] ? w[15:8] : w[7:0])};
         if (k != m_key) m_cnt = 0;
         else if (m_cnt < LIM) m_cnt++;
         m_key = k;
      end
   end

   task automatic check(input string tag, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual %h expected %h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (live && rst_n && !done) begin
         logic [15:0] e_oe;
         bit rd;
         rd   = !ce_n && !oe_n && we_n;
         e_oe = rd ? (wide_cfg ? 16'hffff : 16'h00ff) : 16'h0000;
         check(tag_pins, "dq_oe", 32'(dq_oe), 32'(e_oe));
         check("R3", "byte_addr", 32'(byte_addr), 32'({addr_i, (!wide_cfg) & dq_i[15]}));
         check("R3", "arr_addr", 32'(arr_addr), 32'(addr_i));
         check(tag_data, "dq_o", 32'(dq_o), 32'(m_data));
         check(tag_slp, "asleep", 32'(asleep), 32'(m_cnt == LIM));
      end
   end

   task automatic tick(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         #3;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(20 * 20000);
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      // R10: reset state
      tick(2);
      @(negedge clk);
      check("R10", "asleep in reset", 32'(asleep), 32'd0);
      check("R10", "dq_o in reset", 32'(dq_o), 32'd0);
      @(posedge clk); #3;
      rst_n = 1'b1;
      live  = 1;

      // R1, R4, R6: word mode reads at changing addresses
      tag_pins = "R1"; tag_data = "R4_R6"; tag_slp = "R9";
      ce_n = 0; oe_n = 0; we_n = 1; wide_cfg = 1;
      for (int i = 0; i < 8; i++) begin
         addr_i = AW'(32'h1_0000 + i * 37);
         dq_i   = 16'(i * 16'h1111);
         tick();
      end

      // R2, R3, R4: byte mode, lsb from top pin
      tag_pins = "R2"; tag_data = "R4";
      wide_cfg = 0;
      for (int i = 0; i < 8; i++) begin
         addr_i = AW'(32'h0_0400 + (i / 2));
         dq_i   = {i[0], 15'h2aaa};
         tick();
      end

      // R5: strobe combinations in both modes
      tag_pins = "R5"; tag_data = "R6";
      for (int i = 0; i < 16; i++) begin
         {wide_cfg, ce_n, oe_n, we_n} = 4'(i);
         addr_i = AW'(32'h0_0800 + i);
         tick();
      end

      // R7, R8: stable word address, strobes and top pin toggling
      tag_pins = "R5"; tag_data = "R8"; tag_slp = "R7";
      wide_cfg = 1; addr_i = AW'(32'h3_2100); ce_n = 0; oe_n = 0; we_n = 1;
      tick();
      for (int i = 0; i < LIM + 6; i++) begin
         ce_n  = i[0];
         oe_n  = i[1];
         we_n  = ~i[2];
         dq_i  = {i[0], 15'h0};
         salt  = 16'(salt + 16'h0101);
         tick();
      end
      @(negedge clk);
      check("R7", "asleep after stable word address", 32'(asleep), 32'd1);

      // R9: word address change wakes and reloads
      tag_data = "R9"; tag_slp = "R9";
      ce_n = 0; oe_n = 0; we_n = 1;
      addr_i = AW'(32'h3_2101);
      tick(2);

      // R7, R8 in byte mode, then R9 by top pin alone
      tag_data = "R8"; tag_slp = "R7";
      wide_cfg = 0; addr_i = AW'(32'h0_0055); dq_i = 16'h8000;
      tick();
      for (int i = 0; i < LIM + 3; i++) begin
         salt = 16'(salt ^ 16'h0f0f);
         tick();
      end
      @(negedge clk);
      check("R8", "asleep before lsb flip", 32'(asleep), 32'd1);
      tag_data = "R9"; tag_slp = "R9";
      @(posedge clk); #3;
      dq_i = 16'h0000;
      tick();
      @(negedge clk);
      check("R9", "awake after lsb flip", 32'(asleep), 32'd0);

      // R9: mode change alone wakes
      tag_slp = "R7";
      tick(LIM + 2);
      tag_slp = "R9"; tag_data = "R9";
      wide_cfg = 1;
      tick(3);

      live = 0;
      tick(2);
      finish_run();
   end
endmodule